// File: doc/BRIEF.md
# Event Queue Writer with Generation Bit

This block carries interrupt event numbers from a producer to a consumer through a circular queue of 32-bit words. The producer offers a 31-bit event number with a valid/ready handshake. Each accepted event is stored at the write index, and the top bit of the stored word holds the producer's current generation. That generation bit starts at 1 and inverts every time the write index wraps back to entry 0. A one-cycle notify pulse announces each stored event.

The consumer keeps its own read index and an expected polarity that starts at 0. A word whose top bit equals that polarity is stale. Reading a stale word returns nothing and leaves the index where it is. Reading any other word returns it and advances the index, and the polarity inverts when the read index wraps to 0. No occupancy counter exists: the full test compares the two indices and the two generation bits. A write that would overwrite an unread word is dropped, and an overflow pulse reports the drop. The event number 2^24 is reserved for inter-processor interrupts, and the consumer flags it when it reads one.

Top module: `evq_ring`

## Requirements
- R1: A synchronous active-high reset zeroes every queue word and both indices, sets the consumer polarity to 0 and the producer generation to 1. After reset, ev_ready is 1, and a read returns rd_valid=0 and rd_entry=0.
- R2: An accepted event (ev_valid=1 while ev_ready=1) is stored at the write index as {generation, ev_data}, and the write index then advances modulo DEPTH. Events are read back in the order they were written. During the first lap the generation bit is 1.
- R3: The producer generation inverts each time the write index wraps from DEPTH-1 to 0, so words written in the second lap carry bit 31 = 0.
- R4: notify is high for exactly the one cycle that follows each clock edge at which an event was accepted, and low otherwise.
- R5: A rd_req sampled at a clock edge, against a word whose bit 31 differs from the consumer polarity, gives rd_valid=1 and rd_entry equal to the full 32-bit word in the following cycle, and the read index advances.
- R6: A rd_req against a word whose bit 31 equals the consumer polarity gives rd_valid=0 and rd_entry=0 in the following cycle, and the read index does not move.
- R7: The consumer polarity inverts when the read index wraps to 0, so second-lap words with bit 31 = 0 are accepted as fresh.
- R8: When DEPTH words are unread, ev_ready is 0. An event offered then is dropped: overflow is high for one cycle, notify stays low, and the stored queue contents are unchanged.
- R9: rd_ipi is high together with rd_valid exactly when the event number read is 2^24, and low otherwise.
- R10: A read and a write in the same cycle both take effect. The read sees the queue as it was before that edge, so on an empty queue it returns no event, and the new word is readable afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Producer offers an event |
| ev_data | input | 31 | Event number offered |
| ev_ready | output | 1 | Queue has a free word (not full) |
| notify | output | 1 | One-cycle pulse after each stored event |
| overflow | output | 1 | One-cycle pulse after a dropped event |
| rd_req | input | 1 | Consumer read request |
| rd_valid | output | 1 | Last read returned a fresh word |
| rd_entry | output | 32 | Word returned by the last read, 0 if stale |
| rd_ipi | output | 1 | Word returned carries the reserved IPI number |

## Verification
notify, overflow, rd_valid, rd_entry and rd_ipi are registered, so each one belongs to the single clock edge that sampled its stimulus and is valid for the whole cycle after that edge. ev_ready is derived from the stored indices and generation bits only, so it reflects the state left by the previous edge. The bench drives every stimulus on a falling edge, releases it on the next falling edge, and samples all outputs at that same falling edge. Each sample therefore sits one rising edge after the stimulus and before the next rising edge can change anything.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int EVQ_WORD_W = 32;
  localparam int EVQ_EVT_W  = EVQ_WORD_W - 1;
  localparam int EVQ_GEN_B  = EVQ_WORD_W - 1;
  localparam logic [EVQ_EVT_W-1:0] EVQ_IPI_CODE = EVQ_EVT_W'(32'h0100_0000);

  function automatic logic [EVQ_WORD_W-1:0] evq_pack(input logic gen,
                                                     input logic [EVQ_EVT_W-1:0] evt);
    return {gen, evt};
  endfunction
endpackage

// File: rtl/evq_store.sv
module evq_store
  import evq_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4,
  localparam int DEPTH = 1 << DEPTH_LOG2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [DEPTH_LOG2-1:0] waddr,
  input  logic [EVQ_WORD_W-1:0] wdata,
  input  logic [DEPTH_LOG2-1:0] raddr,
  output logic [EVQ_WORD_W-1:0] rdata
);
  logic [EVQ_WORD_W-1:0] slot [DEPTH];

  // Each word is its own register so reset can clear the whole ring at once.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot[g] <= '0;
      end else if (we && (waddr == DEPTH_LOG2'(g))) begin
        slot[g] <= wdata;
      end
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/evq_producer.sv
module evq_producer
  import evq_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ev_valid_i,
  input  logic [EVQ_EVT_W-1:0]  ev_data_i,
  input  logic [DEPTH_LOG2-1:0] cons_idx_i,
  input  logic                  cons_tog_i,
  output logic                  ev_ready_o,
  output logic                  we_o,
  output logic [DEPTH_LOG2-1:0] waddr_o,
  output logic [EVQ_WORD_W-1:0] wdata_o,
  output logic                  notify_o,
  output logic                  ovf_o
);
  logic [DEPTH_LOG2-1:0] idx_q;
  logic [DEPTH_LOG2-1:0] idx_nxt;
  logic                  gen_q;
  logic                  full;
  logic                  accept;

  // Same index with equal generation and polarity means one full lap is unread.
  assign full    = (idx_q == cons_idx_i) && (gen_q == cons_tog_i);
  assign accept  = ev_valid_i && !full;
  assign idx_nxt = idx_q + DEPTH_LOG2'(1);

  assign ev_ready_o = !full;
  assign we_o       = accept;
  assign waddr_o    = idx_q;
  assign wdata_o    = evq_pack(gen_q, ev_data_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      gen_q    <= 1'b1;
      notify_o <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      notify_o <= accept;
      ovf_o    <= ev_valid_i && full;
      if (accept) begin
        idx_q <= idx_nxt;
        if (idx_nxt == '0) gen_q <= ~gen_q;
      end
    end
  end

  a_r4_notify_after_accept: assert property (@(posedge clk) disable iff (rst)
    (ev_valid_i && ev_ready_o) |=> (notify_o && !ovf_o));

  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (ev_valid_i && !ev_ready_o) |=> (ovf_o && !notify_o));

  a_r3_gen_flips_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (gen_q != $past(gen_q)) |-> (idx_q == '0));
endmodule

// File: rtl/evq_consumer.sv
module evq_consumer
  import evq_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_req_i,
  input  logic [EVQ_WORD_W-1:0] word_i,
  output logic [DEPTH_LOG2-1:0] idx_o,
  output logic                  tog_o,
  output logic                  rd_valid_o,
  output logic [EVQ_WORD_W-1:0] rd_entry_o,
  output logic                  rd_ipi_o
);
  logic [DEPTH_LOG2-1:0] idx_q;
  logic [DEPTH_LOG2-1:0] idx_nxt;
  logic                  tog_q;
  logic                  fresh;

  assign fresh   = word_i[EVQ_GEN_B] != tog_q;
  assign idx_nxt = idx_q + DEPTH_LOG2'(1);
  assign idx_o   = idx_q;
  assign tog_o   = tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      tog_q      <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_entry_o <= '0;
      rd_ipi_o   <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      rd_entry_o <= '0;
      rd_ipi_o   <= 1'b0;
      if (rd_req_i && fresh) begin
        rd_valid_o <= 1'b1;
        rd_entry_o <= word_i;
        rd_ipi_o   <= (word_i[EVQ_EVT_W-1:0] == EVQ_IPI_CODE);
        idx_q      <= idx_nxt;
        if (idx_nxt == '0) tog_q <= ~tog_q;
      end
    end
  end

  a_r5_valid_needs_request: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_req_i));

  a_r6_stale_holds_index: assert property (@(posedge clk) disable iff (rst)
    (rd_req_i && (word_i[EVQ_GEN_B] == tog_q)) |=> (!rd_valid_o && $stable(idx_q)));

  a_r7_tog_flips_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (tog_q != $past(tog_q)) |-> (idx_q == '0));

  a_r9_ipi_only_when_valid: assert property (@(posedge clk) disable iff (rst)
    rd_ipi_o |-> rd_valid_o);
endmodule

// File: rtl/evq_ring.sv
module evq_ring
  import evq_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_valid,
  input  logic [EVQ_EVT_W-1:0] ev_data,
  output logic                 ev_ready,
  output logic                 notify,
  output logic                 overflow,
  input  logic                 rd_req,
  output logic                 rd_valid,
  output logic [EVQ_WORD_W-1:0] rd_entry,
  output logic                 rd_ipi
);
  logic                  we;
  logic [DEPTH_LOG2-1:0] waddr;
  logic [EVQ_WORD_W-1:0] wdata;
  logic [DEPTH_LOG2-1:0] ridx;
  logic                  rtog;
  logic [EVQ_WORD_W-1:0] rword;

  evq_producer #(.DEPTH_LOG2(DEPTH_LOG2)) u_prod (
    .clk(clk), .rst(rst),
    .ev_valid_i(ev_valid), .ev_data_i(ev_data),
    .cons_idx_i(ridx), .cons_tog_i(rtog),
    .ev_ready_o(ev_ready), .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .notify_o(notify), .ovf_o(overflow)
  );

  evq_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_store (
    .clk(clk), .rst(rst),
    .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ridx), .rdata(rword)
  );

  evq_consumer #(.DEPTH_LOG2(DEPTH_LOG2)) u_cons (
    .clk(clk), .rst(rst),
    .rd_req_i(rd_req), .word_i(rword),
    .idx_o(ridx), .tog_o(rtog),
    .rd_valid_o(rd_valid), .rd_entry_o(rd_entry), .rd_ipi_o(rd_ipi)
  );

  a_r2_no_write_over_unread: assert property (@(posedge clk) disable iff (rst)
    we |-> !((waddr == ridx) && (rword[EVQ_GEN_B] != rtog)));
endmodule

// File: tb/sim_evq_ring.sv
`timescale 1ns/1ps
module sim_evq_ring;
  localparam int DL2 = 4;
  localparam int DEPTH = 1 << DL2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [30:0] ev_data = '0;
  logic        rd_req = 1'b0;
  logic        ev_ready, notify, overflow, rd_valid, rd_ipi;
  logic [31:0] rd_entry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evq_ring #(.DEPTH_LOG2(DL2)) u0 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_data(ev_data),
    .ev_ready(ev_ready), .notify(notify), .overflow(overflow),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_entry(rd_entry), .rd_ipi(rd_ipi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; outputs are sampled at the next falling edge.
  task automatic op(input logic wv, input logic [30:0] wd, input logic rr);
    ev_valid = wv; ev_data = wd; rd_req = rr;
    @(negedge clk);
    ev_valid = 1'b0; ev_data = '0; rd_req = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Fields: wv, wd[30:0], rr, exp_valid, exp_entry[31:0], exp_notify, exp_ovf, exp_ipi
  localparam logic [68:0] VEC [0:7] = '{
    {1'b1, 31'h11,      1'b0, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0},
    {1'b1, 31'h22,      1'b0, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0},
    {1'b0, 31'h0,       1'b1, 1'b1, 32'h8000_0011, 1'b0, 1'b0, 1'b0},
    {1'b1, 31'h33,      1'b1, 1'b1, 32'h8000_0022, 1'b1, 1'b0, 1'b0},
    {1'b0, 31'h0,       1'b1, 1'b1, 32'h8000_0033, 1'b0, 1'b0, 1'b0},
    {1'b0, 31'h0,       1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0},
    {1'b1, 31'h100_0000,1'b0, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0},
    {1'b0, 31'h0,       1'b1, 1'b1, 32'h8100_0000, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: state right after reset
    check("R1 ready", 32'(ev_ready), 32'd1);
    check("R1 notify/ovf", {30'd0, notify, overflow}, 32'd0);
    op(1'b0, '0, 1'b1);
    check("R1 empty read valid", 32'(rd_valid), 32'd0);
    check("R1 empty read entry", rd_entry, 32'd0);

    // Vector table: R2 R4 R5 R6 R9 R10
    for (int i = 0; i < 8; i++) begin
      op(VEC[i][68], VEC[i][67:37], VEC[i][36]);
      check($sformatf("R5 vec%0d valid", i), 32'(rd_valid), 32'(VEC[i][35]));
      check($sformatf("R2 vec%0d entry", i), rd_entry, VEC[i][34:3]);
      check($sformatf("R4 vec%0d notify", i), 32'(notify), 32'(VEC[i][2]));
      check($sformatf("R8 vec%0d ovf", i), 32'(overflow), 32'(VEC[i][1]));
      check($sformatf("R9 vec%0d ipi", i), 32'(rd_ipi), 32'(VEC[i][0]));
    end
    // Indices now both at 4, queue empty.

    // R8: fill to full, then one more is dropped
    for (int i = 0; i < DEPTH; i++) begin
      op(1'b1, 31'(32'h100 + i), 1'b0);
      check("R4 fill notify", 32'(notify), 32'd1);
    end
    check("R8 ready low when full", 32'(ev_ready), 32'd0);
    op(1'b1, 31'h7FF, 1'b0);
    check("R8 overflow pulse", 32'(overflow), 32'd1);
    check("R8 no notify on drop", 32'(notify), 32'd0);
    @(negedge clk);
    check("R8 overflow one cycle", 32'(overflow), 32'd0);

    // Drain: R3 second-lap words carry gen 0, R7 consumer accepts them
    for (int i = 0; i < DEPTH; i++) begin
      op(1'b0, '0, 1'b1);
      check("R7 drain valid", 32'(rd_valid), 32'd1);
      check("R3 drain entry", rd_entry,
            {(i < DEPTH - 4) ? 1'b1 : 1'b0, 31'(32'h100 + i)});
      check("R9 drain no ipi", 32'(rd_ipi), 32'd0);
    end
    op(1'b0, '0, 1'b1);
    check("R8 dropped event absent", 32'(rd_valid), 32'd0);
    check("R6 stale entry zero", rd_entry, 32'd0);
    check("R8 ready after drain", 32'(ev_ready), 32'd1);

    // R10: simultaneous write and read on an empty queue
    op(1'b1, 31'h55, 1'b1);
    check("R10 read sees old state", 32'(rd_valid), 32'd0);
    check("R10 write notifies", 32'(notify), 32'd1);
    op(1'b0, '0, 1'b1);
    check("R10 word readable after", rd_entry, 32'h0000_0055);

    // R1: reset mid-stream clears stored words
    op(1'b1, 31'h66, 1'b0);
    op(1'b1, 31'h77, 1'b0);
    do_reset();
    check("R1 ready after reset", 32'(ev_ready), 32'd1);
    op(1'b0, '0, 1'b1);
    check("R1 cleared read valid", 32'(rd_valid), 32'd0);
    check("R1 cleared read entry", rd_entry, 32'd0);
    op(1'b1, 31'h88, 1'b0);
    op(1'b0, '0, 1'b1);
    check("R2 first lap gen after reset", rd_entry, 32'h8000_0088);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule